// File: doc/BRIEF.md
# Encoded Bus-Source Control Decoder

This block sits between a microcode store and the 8-bit shared data bus of a small processor. Each cycle it captures a 16-bit control word and splits it into fields. A 4-bit source field is decoded into one-hot output enables, so that exactly one bus source is selected at a time. Two smaller binary fields are decoded into destination load strobes. The remaining seven bits pass straight through as single-purpose strobes.

The block also multiplexes the selected source onto the bus. The sources are the seven general registers A, B, C, D, E, H and L, the temp register, the two bytes of the program counter, the ALU result, two input ports and memory read data. Because the selection is held in a binary field, two drivers can never be enabled together. A conflict output exists for a checker to watch, and it is expected to stay low at all times.

Top module: `bus_ctl_decoder`

## Requirements
- R1: While `rst_n` is low, the captured control word is zero. As a result, `src_oe` equals 16'h0001, all load strobes and `misc` are zero, and `bus_out` is 0x00.
- R2: The control word is registered on the rising edge of `clk`. Every output is a combinational function of the last captured word, so a change on `cw_in` between edges has no effect until the next edge.
- R3: Bits [3:0] hold the source code k. `src_oe[k]` is high and every other bit of `src_oe` is low, so exactly one bit is set in every cycle. Bit 0 means the bus is idle.
- R4: The source codes drive `bus_out` as follows: 1 A, 2 B, 3 C, 4 D, 5 E, 6 H, 7 L, 8 temp, 9 counter high byte, 10 counter low byte, 11 ALU result, 12 input port 1, 13 input port 2, 14 memory data.
- R5: Source codes 0 and 15 drive no source, and `bus_out` then reads 0x00.
- R6: Bits [6:4] hold v. For v from 1 to 7, `ld_reg[v-1]` is raised, with bits 0 to 6 standing for A, B, C, D, E, H, L. When v is 0, no bit is raised. At most one bit is ever high.
- R7: Bits [8:7] hold u. For u from 1 to 3, `ld_aux[u-1]` is raised, with bit 0 for temp, bit 1 for address low and bit 2 for address high. When u is 0, no bit is raised.
- R8: Bits [15:9] appear unchanged on `misc[6:0]`.
- R9: `bus_conflict` is high only when more than one bit of `src_oe` is high. It therefore stays low in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_in | input | 16 | Control word from the microcode store |
| reg_a | input | 8 | Register A |
| reg_b | input | 8 | Register B |
| reg_c | input | 8 | Register C |
| reg_d | input | 8 | Register D |
| reg_e | input | 8 | Register E |
| reg_h | input | 8 | Register H |
| reg_l | input | 8 | Register L |
| reg_tmp | input | 8 | Temp register |
| pc_hi | input | 8 | Program counter high byte |
| pc_lo | input | 8 | Program counter low byte |
| alu_res | input | 8 | ALU result |
| port_in1 | input | 8 | Input port 1 |
| port_in2 | input | 8 | Input port 2 |
| mem_rd | input | 8 | Memory read data |
| src_oe | output | 16 | One-hot source enables, indexed by source code |
| bus_out | output | 8 | Shared bus value |
| ld_reg | output | 7 | Load strobes for A, B, C, D, E, H, L |
| ld_aux | output | 3 | Load strobes for temp, address low, address high |
| misc | output | 7 | Pass-through strobes |
| bus_conflict | output | 1 | High if more than one source is enabled |

## Verification
Two functions can act in the same cycle: driving a source onto the bus, and loading a destination from it. A transfer word such as "register C to register H" exercises both at once. The bench gives every source a distinct byte, so a wrong selection shows up as a wrong bus value. Each such cycle is judged on three things together: the bus value, the exact one-hot source enable, and a single load strobe in the expected position. The other load strobes and the pass-through bits must not move.

// File: rtl/bus_ctl_decoder.sv
module bus_ctl_decoder #(
  parameter int W  = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cw_in,
  input  logic [W-1:0]  reg_a,
  input  logic [W-1:0]  reg_b,
  input  logic [W-1:0]  reg_c,
  input  logic [W-1:0]  reg_d,
  input  logic [W-1:0]  reg_e,
  input  logic [W-1:0]  reg_h,
  input  logic [W-1:0]  reg_l,
  input  logic [W-1:0]  reg_tmp,
  input  logic [W-1:0]  pc_hi,
  input  logic [W-1:0]  pc_lo,
  input  logic [W-1:0]  alu_res,
  input  logic [W-1:0]  port_in1,
  input  logic [W-1:0]  port_in2,
  input  logic [W-1:0]  mem_rd,
  output logic [15:0]   src_oe,
  output logic [W-1:0]  bus_out,
  output logic [6:0]    ld_reg,
  output logic [2:0]    ld_aux,
  output logic [CW-10:0] misc,
  output logic          bus_conflict
);

  localparam int SRC_W = 4;
  localparam int NSRC  = 1 << SRC_W;

  logic [CW-1:0]    cw_q;
  logic [SRC_W-1:0] src_code;
  logic [2:0]       reg_code;
  logic [1:0]       aux_code;
  logic [4:0]       oe_count;

  // R2: control word held for one cycle, everything below is combinational
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cw_q <= '0;
    else        cw_q <= cw_in;

  assign src_code = cw_q[3:0];
  assign reg_code = cw_q[6:4];
  assign aux_code = cw_q[8:7];
  assign misc     = cw_q[CW-1:9];

  // R3: 4-to-16 source decode
  always_comb begin
    src_oe = '0;
    for (int k = 0; k < NSRC; k++)
      if (src_code == SRC_W'(k)) src_oe[k] = 1'b1;
  end

  // R6: 3-to-8 decode, code 0 is idle
  always_comb begin
    ld_reg = '0;
    for (int k = 1; k < 8; k++)
      if (reg_code == 3'(k)) ld_reg[k-1] = 1'b1;
  end

  // R7: 2-to-4 decode, code 0 is idle
  always_comb begin
    ld_aux = '0;
    for (int k = 1; k < 4; k++)
      if (aux_code == 2'(k)) ld_aux[k-1] = 1'b1;
  end

  // R4, R5: bus multiplexer driven by the decoded enables
  always_comb begin
    bus_out = '0;
    unique case (1'b1)
      src_oe[1]:  bus_out = reg_a;
      src_oe[2]:  bus_out = reg_b;
      src_oe[3]:  bus_out = reg_c;
      src_oe[4]:  bus_out = reg_d;
      src_oe[5]:  bus_out = reg_e;
      src_oe[6]:  bus_out = reg_h;
      src_oe[7]:  bus_out = reg_l;
      src_oe[8]:  bus_out = reg_tmp;
      src_oe[9]:  bus_out = pc_hi;
      src_oe[10]: bus_out = pc_lo;
      src_oe[11]: bus_out = alu_res;
      src_oe[12]: bus_out = port_in1;
      src_oe[13]: bus_out = port_in2;
      src_oe[14]: bus_out = mem_rd;
      default:    bus_out = '0;
    endcase
  end

  // R9: count active enables
  always_comb begin
    oe_count = '0;
    for (int k = 0; k < NSRC; k++)
      oe_count = oe_count + {4'd0, src_oe[k]};
  end
  assign bus_conflict = (oe_count > 5'd1);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (src_oe == 16'h0001 && ld_reg == '0 && ld_aux == '0));

  assert_registered_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (misc == $past(cw_in[CW-1:9])));

  assert_one_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(src_oe));

  assert_idle_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_oe[0] || src_oe[15]) |-> (bus_out == '0));

  assert_single_reg_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_reg));

  assert_single_aux_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_aux));

  assert_no_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_conflict);

endmodule

// File: tb/bus_ctl_decoder_test.sv
module bus_ctl_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cw_in = '0;
  logic [7:0]  reg_a = 8'h11, reg_b = 8'h22, reg_c = 8'h33, reg_d = 8'h44;
  logic [7:0]  reg_e = 8'h55, reg_h = 8'h66, reg_l = 8'h77, reg_tmp = 8'h88;
  logic [7:0]  pc_hi = 8'h99, pc_lo = 8'hAA, alu_res = 8'hBB;
  logic [7:0]  port_in1 = 8'hCC, port_in2 = 8'hDD, mem_rd = 8'hEE;
  logic [15:0] src_oe;
  logic [7:0]  bus_out;
  logic [6:0]  ld_reg;
  logic [2:0]  ld_aux;
  logic [6:0]  misc;
  logic        bus_conflict;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_ctl_decoder uut (
    .clk(clk), .rst_n(rst_n), .cw_in(cw_in),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
    .reg_e(reg_e), .reg_h(reg_h), .reg_l(reg_l), .reg_tmp(reg_tmp),
    .pc_hi(pc_hi), .pc_lo(pc_lo), .alu_res(alu_res),
    .port_in1(port_in1), .port_in2(port_in2), .mem_rd(mem_rd),
    .src_oe(src_oe), .bus_out(bus_out), .ld_reg(ld_reg), .ld_aux(ld_aux),
    .misc(misc), .bus_conflict(bus_conflict)
  );

  function automatic logic [7:0] exp_bus(input int code);
    case (code)
      1: return 8'h11;  2: return 8'h22;  3: return 8'h33;  4: return 8'h44;
      5: return 8'h55;  6: return 8'h66;  7: return 8'h77;  8: return 8'h88;
      9: return 8'h99;  10: return 8'hAA; 11: return 8'hBB; 12: return 8'hCC;
      13: return 8'hDD; 14: return 8'hEE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] mk_cw(input int src, input int rd, input int ax, input int ms);
    return {7'(ms), 2'(ax), 3'(rd), 4'(src)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk) cw_in = w;
    @(negedge clk);
  endtask

  task automatic check_word(input string req, input int src, input int rd, input int ax, input int ms);
    chk(req, "src_oe", 32'(src_oe), 32'(16'h1 << src));
    chk(req, "bus_out", 32'(bus_out), 32'(exp_bus(src)));
    chk(req, "ld_reg", 32'(ld_reg), rd == 0 ? 32'h0 : 32'(7'h1 << (rd - 1)));
    chk(req, "ld_aux", 32'(ld_aux), ax == 0 ? 32'h0 : 32'(3'h1 << (ax - 1)));
    chk(req, "misc", 32'(misc), 32'(ms));
    chk("R9", "bus_conflict", 32'(bus_conflict), 32'h0);
  endtask

  task automatic t_reset;
    cw_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    check_word("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_word("R1", 15, 7, 3, 7'h7F);
  endtask

  task automatic t_sources;
    for (int s = 0; s < 16; s++) begin
      apply(mk_cw(s, 0, 0, 0));
      if (s == 0 || s == 15) check_word("R5", s, 0, 0, 0);
      else check_word("R4", s, 0, 0, 0);
      chk("R3", "onehot", 32'($countones(src_oe)), 32'd1);
    end
  endtask

  task automatic t_reg_loads;
    for (int v = 0; v < 8; v++) begin
      apply(mk_cw(0, v, 0, 0));
      check_word("R6", 0, v, 0, 0);
    end
  endtask

  task automatic t_aux_loads;
    for (int u = 0; u < 4; u++) begin
      apply(mk_cw(0, 0, u, 0));
      check_word("R7", 0, 0, u, 0);
    end
  endtask

  task automatic t_misc;
    apply(mk_cw(0, 0, 0, 7'h55));
    check_word("R8", 0, 0, 0, 7'h55);
    apply(mk_cw(0, 0, 0, 7'h2A));
    check_word("R8", 0, 0, 0, 7'h2A);
  endtask

  task automatic t_hold;
    apply(mk_cw(2, 1, 1, 7'h01));
    cw_in = mk_cw(11, 5, 2, 7'h40);
    #1;
    check_word("R2", 2, 1, 1, 7'h01);
    @(negedge clk);
    check_word("R2", 11, 5, 2, 7'h40);
  endtask

  task automatic t_transfer;
    apply(mk_cw(3, 6, 0, 7'h10));
    check_word("R4", 3, 6, 0, 7'h10);
    apply(mk_cw(14, 0, 1, 7'h03));
    check_word("R4", 14, 0, 1, 7'h03);
    reg_c = 8'h5A;
    #1;
    chk("R4", "bus follows new source", 32'(bus_out), 32'(8'hEE));
    apply(mk_cw(3, 1, 3, 0));
    chk("R4", "bus_out C", 32'(bus_out), 32'(8'h5A));
    reg_c = 8'h33;
  endtask

  initial begin
    t_reset;
    t_sources;
    t_reg_loads;
    t_aux_loads;
    t_misc;
    t_hold;
    t_transfer;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule